// File: doc/BRIEF.md
# Triple-DES Block Cipher Engine

This block encrypts or decrypts a single 64-bit block with the triple data encryption algorithm. It contains one DES round datapath: the permutations, key schedule, expansion, substitution boxes and round permutation. A small sequencer runs that datapath for three DES passes in a row, 16 rounds each and one round per clock.

Each pass takes its own key and its own direction from a two-bit keying-mode select and a direction bit. The result is held on `dout` and is announced by a one-cycle `done` pulse. The engine works on one block at a time. A `start` that arrives while a block is in flight is dropped, and every operand is captured only on the clock edge that accepts `start`.

Top module: `tdes_engine`

## Requirements
- R1: With `mode`=2'b01 (encrypt-decrypt-encrypt, three keys) and `key_a`=`key_b`=`key_c`=K, encryption equals single DES under K. Examples: K=133457799BBCDFF1 and block 0123456789ABCDEF give 85E813540F0AB405; K=0101010101010101 and block 8000000000000000 give 95F8A5E5DD31D900.
- R2: The least significant bit of every key byte (bits 0, 8, ..., 56) is a parity bit that is dropped, so flipping any of these bits leaves the result unchanged.
- R3: With `decrypt`=0 and `mode`=2'b01, `dout` = E(key_c, D(key_b, E(key_a, din))).
- R4: With `decrypt`=1 and `mode`=2'b01, `dout` = D(key_a, E(key_b, D(key_c, din))), which undoes R3.
- R5: With `mode`=2'b00 (three encryptions, three keys), encryption gives E(key_c, E(key_b, E(key_a, din))). Decryption gives D(key_a, D(key_b, D(key_c, din))), which undoes it.
- R6: `mode`=2'b10 and `mode`=2'b11 behave like 2'b00 and 2'b01 with `key_a` standing in for the third key, so `key_c` has no effect.
- R7: `start` is accepted on a rising edge when the engine is idle. `done` is then high after the 50th rising edge, counting the accepting edge as the first. A new `start` can be accepted on the very next edge.
- R8: `done` is high for exactly one cycle per accepted block.
- R9: `dout` changes only on the edge that raises `done`, and holds its value until the next result.
- R10: A `start` seen while a block is in flight, including the final output cycle, is ignored. Operand inputs that change after acceptance have no effect on the result.
- R11: After reset `done` is 0 and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to process one block, taken only when idle |
| decrypt | input | 1 | 0 = triple encryption, 1 = triple decryption |
| mode | input | 2 | 00 three encryptions / three keys, 01 E-D-E / three keys, 10 three encryptions / two keys, 11 E-D-E / two keys |
| key_a | input | 64 | First key (K1), parity in each byte's LSB |
| key_b | input | 64 | Second key (K2) |
| key_c | input | 64 | Third key (K3), unused in two-key modes |
| din | input | 64 | Input block |
| dout | output | 64 | Result block, registered |
| done | output | 1 | One-cycle pulse when `dout` holds a new result |

## Verification
The assertions assume that reset is applied before the first accepted `start`. The latency counter relies on this, because it begins only at an accepted request and treats each `done` as closing exactly one such request. They place no stability demand on the operand inputs. The stimulus holds and toggles `start` and rewrites operands while a block is in flight, and pulses `start` during the final output cycle. The scoreboard therefore expects one result per accepted request and flags any extra `done` as a fault. Expected values come from published single-DES answers and from identities of the mode algebra: weak keys whose encryption is its own inverse, repeated keys that cancel a decrypt-encrypt pair, and round trips with unrelated keys.

// File: rtl/tdes_pkg.sv
package tdes_pkg;
  localparam int BLK_W  = 64;
  localparam int HALF_W = BLK_W / 2;
  localparam int CD_W   = 56;
  localparam int HCD_W  = CD_W / 2;
  localparam int SUB_W  = 48;
  localparam int ROUNDS = 16;
  localparam int PASSES = 3;
  localparam int RND_W  = $clog2(ROUNDS);
  localparam int PASS_W = $clog2(PASSES + 1);
  localparam int LATENCY = ROUNDS * PASSES + 2;

  typedef enum logic [1:0] {
    TM_EEE3 = 2'b00, TM_EDE3 = 2'b01, TM_EEE2 = 2'b10, TM_EDE2 = 2'b11
  } tmode_e;

  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_OUT} seq_st_e;

  localparam int P_TAB [32] = '{16,7,20,21,29,12,28,17,1,15,23,26,5,18,31,10,
                                2,8,24,14,32,27,3,9,19,13,30,6,22,11,4,25};
  localparam int PC1_TAB [56] = '{57,49,41,33,25,17,9,1,58,50,42,34,26,18,
                                  10,2,59,51,43,35,27,19,11,3,60,52,44,36,
                                  63,55,47,39,31,23,15,7,62,54,46,38,30,22,
                                  14,6,61,53,45,37,29,21,13,5,28,20,12,4};
  localparam int PC2_TAB [48] = '{14,17,11,24,1,5,3,28,15,6,21,10,
                                  23,19,12,4,26,8,16,7,27,20,13,2,
                                  41,52,31,37,47,55,30,40,51,45,33,48,
                                  44,49,39,56,34,53,46,42,50,36,29,32};
  // one 64-bit word per box row, column 0 in the top nibble
  localparam logic [63:0] SBOX_T [8][4] = '{
    '{64'hE4D12FB83A6C5907, 64'h0F74E2D1A6CB9538, 64'h41E8D62BFC973A50, 64'hFC8249175B3EA06D},
    '{64'hF18E6B34972DC05A, 64'h3D47F28EC01A69B5, 64'h0E7BA4D158C6932F, 64'hD8A13F42B67C05E9},
    '{64'hA09E63F51DC7B428, 64'hD709346A285ECBF1, 64'hD6498F30B12C5AE7, 64'h1AD069874FE3B52C},
    '{64'h7DE3069A1285BC4F, 64'hD8B56F03472C1AE9, 64'hA690CB7DF13E5284, 64'h3F06A1D8945BC72E},
    '{64'h2C417AB6853FD0E9, 64'hEB2C47D150FA3986, 64'h421BAD78F9C5630E, 64'hB8C71E2D6F09A453},
    '{64'hC1AF92680D34E75B, 64'hAF427C9561DE0B38, 64'h9EF528C3704A1DB6, 64'h432C95FABE17608D},
    '{64'h4B2EF08D3C975A61, 64'hD0B7491AE35C2F86, 64'h14BDC37EAF680592, 64'h6BD814A7950FE23C},
    '{64'hD2846FB1A93E50C7, 64'h1FD8A374C56B0E92, 64'h7B419CE206ADF358, 64'h21E74A8DFC90356B}};

  // source bit (1 = MSB) of initial-permutation output position j (0-based)
  function automatic int ip_src(input int j);
    int r, c;
    r = j / 8;
    c = j % 8;
    return ((r < 4) ? (58 + 2 * r) : (57 + 2 * (r - 4))) - 8 * c;
  endfunction

  function automatic logic [63:0] perm_ip(input logic [63:0] x);
    logic [63:0] y;
    y = '0;
    for (int j = 0; j < 64; j++) y[63-j] = x[64-ip_src(j)];
    return y;
  endfunction

  function automatic logic [63:0] perm_fp(input logic [63:0] x);
    logic [63:0] y;
    y = '0;
    for (int j = 0; j < 64; j++) y[64-ip_src(j)] = x[63-j];
    return y;
  endfunction

  function automatic logic [CD_W-1:0] perm_pc1(input logic [63:0] k);
    logic [CD_W-1:0] y;
    y = '0;
    for (int j = 0; j < CD_W; j++) y[CD_W-1-j] = k[64-PC1_TAB[j]];
    return y;
  endfunction

  function automatic logic [SUB_W-1:0] perm_pc2(input logic [CD_W-1:0] cd);
    logic [SUB_W-1:0] y;
    y = '0;
    for (int j = 0; j < SUB_W; j++) y[SUB_W-1-j] = cd[CD_W-PC2_TAB[j]];
    return y;
  endfunction

  function automatic logic [3:0] sbox_lu(input int i, input logic [5:0] v);
    logic [63:0] w;
    logic [3:0]  col;
    w   = SBOX_T[i][{v[5], v[0]}];
    col = v[4:1];
    return w[63-4*int'(col) -: 4];
  endfunction

  function automatic logic [HALF_W-1:0] round_f(input logic [HALF_W-1:0] r,
                                                input logic [SUB_W-1:0] k);
    logic [SUB_W-1:0]  e;
    logic [HALF_W-1:0] s, y;
    e = '0;
    for (int j = 0; j < SUB_W; j++) e[SUB_W-1-j] = r[HALF_W-1-(((j/6)*4 + j%6 + 31) % 32)];
    e = e ^ k;
    s = '0;
    for (int i = 0; i < 8; i++) s[31-4*i -: 4] = sbox_lu(i, e[47-6*i -: 6]);
    y = '0;
    for (int j = 0; j < HALF_W; j++) y[HALF_W-1-j] = s[HALF_W-P_TAB[j]];
    return y;
  endfunction

  function automatic logic [1:0] enc_shift(input logic [RND_W-1:0] r);
    return (r == 0 || r == 1 || r == 8 || r == RND_W'(ROUNDS - 1)) ? 2'd1 : 2'd2;
  endfunction

  // reverse schedule: no move before the first decrypt round
  function automatic logic [1:0] dec_shift(input logic [RND_W-1:0] r);
    return (r == 0) ? 2'd0 : enc_shift(RND_W'(0) - r);
  endfunction

  function automatic logic [HCD_W-1:0] rot_left(input logic [HCD_W-1:0] x, input logic [1:0] n);
    case (n)
      2'd1:    return {x[HCD_W-2:0], x[HCD_W-1]};
      2'd2:    return {x[HCD_W-3:0], x[HCD_W-1:HCD_W-2]};
      default: return x;
    endcase
  endfunction

  function automatic logic [HCD_W-1:0] rot_right(input logic [HCD_W-1:0] x, input logic [1:0] n);
    case (n)
      2'd1:    return {x[0], x[HCD_W-1:1]};
      2'd2:    return {x[1:0], x[HCD_W-1:2]};
      default: return x;
    endcase
  endfunction

  // direction of pass p: inverted in the middle for E-D-E modes
  function automatic logic pass_dec(input logic dir, input logic [1:0] md, input logic [PASS_W-1:0] p);
    return dir ^ (md[0] && p == PASS_W'(1));
  endfunction

  // key index for pass p: 0 = key_a, 1 = key_b, 2 = key_c
  function automatic logic [1:0] pass_key(input logic dir, input logic [1:0] md, input logic [PASS_W-1:0] p);
    logic [1:0] third;
    third = md[1] ? 2'd0 : 2'd2;
    if (p == PASS_W'(1)) return 2'd1;
    if (p == PASS_W'(0)) return dir ? third : 2'd0;
    return dir ? 2'd0 : third;
  endfunction
endpackage

// File: rtl/tdes_keysched.sv
module tdes_keysched
  import tdes_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BLK_W-1:0]  key_in,
  input  logic              step,
  input  logic              dec,
  input  logic [RND_W-1:0]  rnd,
  output logic [SUB_W-1:0]  subkey
);
  logic [HCD_W-1:0] c_q, d_q, c_e, d_e;
  logic [1:0]       amt;

  always_comb begin
    amt = dec ? dec_shift(rnd) : enc_shift(rnd);
    c_e = dec ? rot_right(c_q, amt) : rot_left(c_q, amt);
    d_e = dec ? rot_right(d_q, amt) : rot_left(d_q, amt);
    subkey = perm_pc2({c_e, d_e});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_q <= '0;
      d_q <= '0;
    end else if (load) begin
      {c_q, d_q} <= perm_pc1(key_in);
    end else if (step) begin
      c_q <= c_e;
      d_q <= d_e;
    end
  end
endmodule

// File: rtl/tdes_round.sv
module tdes_round
  import tdes_pkg::*;
(
  input  logic [HALF_W-1:0] l_in,
  input  logic [HALF_W-1:0] r_in,
  input  logic [SUB_W-1:0]  subkey,
  output logic [HALF_W-1:0] l_out,
  output logic [HALF_W-1:0] r_out
);
  always_comb begin
    l_out = r_in;
    r_out = l_in ^ round_f(r_in, subkey);
  end
endmodule

// File: rtl/tdes_seq.sv
module tdes_seq
  import tdes_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             dir_in,
  input  logic [1:0]       mode_in,
  output logic             accept,
  output logic             busy,
  output logic             load,
  output logic             step,
  output logic             last_rnd,
  output logic             fire,
  output logic             dec,
  output logic [1:0]       key_sel,
  output logic [RND_W-1:0] rnd
);
  localparam logic [RND_W-1:0]  RND_LAST  = RND_W'(ROUNDS - 1);
  localparam logic [PASS_W-1:0] PASS_LAST = PASS_W'(PASSES - 1);

  seq_st_e           st_q;
  logic [PASS_W-1:0] pass_q;
  logic [RND_W-1:0]  rnd_q;
  logic [1:0]        mode_q;
  logic              dir_q, dec_q;

  always_comb begin
    busy     = (st_q != SQ_IDLE);
    accept   = start && !busy;
    step     = (st_q == SQ_RUN);
    last_rnd = step && (rnd_q == RND_LAST);
    fire     = (st_q == SQ_OUT);
    load     = accept || (last_rnd && pass_q != PASS_LAST);
    key_sel  = accept ? pass_key(dir_in, mode_in, '0)
                      : pass_key(dir_q, mode_q, pass_q + PASS_W'(1));
    dec      = dec_q;
    rnd      = rnd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SQ_IDLE;
      pass_q <= '0;
      rnd_q  <= '0;
      mode_q <= '0;
      dir_q  <= 1'b0;
      dec_q  <= 1'b0;
    end else begin
      case (st_q)
        SQ_IDLE: if (accept) begin
          dir_q  <= dir_in;
          mode_q <= mode_in;
          pass_q <= '0;
          rnd_q  <= '0;
          dec_q  <= pass_dec(dir_in, mode_in, '0);
          st_q   <= SQ_RUN;
        end
        SQ_RUN: begin
          rnd_q <= last_rnd ? '0 : rnd_q + RND_W'(1);
          if (last_rnd) begin
            if (pass_q == PASS_LAST) st_q <= SQ_OUT;
            else begin
              pass_q <= pass_q + PASS_W'(1);
              dec_q  <= pass_dec(dir_q, mode_q, pass_q + PASS_W'(1));
            end
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tdes_engine.sv
module tdes_engine
  import tdes_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             decrypt,
  input  logic [1:0]       mode,
  input  logic [BLK_W-1:0] key_a,
  input  logic [BLK_W-1:0] key_b,
  input  logic [BLK_W-1:0] key_c,
  input  logic [BLK_W-1:0] din,
  output logic [BLK_W-1:0] dout,
  output logic             done
);
  logic              acc, busy, load, step, last_rnd, fire, dec;
  logic [1:0]        key_sel;
  logic [RND_W-1:0]  rnd;
  logic [BLK_W-1:0]  kq_a, kq_b, kq_c, ks_key;
  logic [HALF_W-1:0] l_q, r_q, l_n, r_n;
  logic [SUB_W-1:0]  subkey;

  tdes_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .dir_in(decrypt), .mode_in(mode),
    .accept(acc), .busy(busy), .load(load), .step(step), .last_rnd(last_rnd),
    .fire(fire), .dec(dec), .key_sel(key_sel), .rnd(rnd)
  );

  // on the accepting edge the key comes straight from the pins
  always_comb begin
    case (key_sel)
      2'd0:    ks_key = acc ? key_a : kq_a;
      2'd1:    ks_key = acc ? key_b : kq_b;
      default: ks_key = acc ? key_c : kq_c;
    endcase
  end

  tdes_keysched u_ks (
    .clk(clk), .rst(rst), .load(load), .key_in(ks_key), .step(step),
    .dec(dec), .rnd(rnd), .subkey(subkey)
  );

  tdes_round u_rnd (
    .l_in(l_q), .r_in(r_q), .subkey(subkey), .l_out(l_n), .r_out(r_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      kq_a <= '0;
      kq_b <= '0;
      kq_c <= '0;
      l_q  <= '0;
      r_q  <= '0;
      dout <= '0;
      done <= 1'b0;
    end else begin
      done <= fire;
      if (acc) begin
        kq_a <= key_a;
        kq_b <= key_b;
        kq_c <= key_c;
        {l_q, r_q} <= perm_ip(din);
      end else if (step) begin
        // after round 16 the halves swap; the next pass's initial
        // permutation undoes this pass's final one, so both are skipped
        if (last_rnd) {l_q, r_q} <= {r_n, l_n};
        else          {l_q, r_q} <= {l_n, r_n};
      end
      if (fire) dout <= perm_fp({l_q, r_q});
    end
  end
endmodule

// File: rtl/tdes_engine_chk.sv
module tdes_engine_chk
  import tdes_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             done,
  input logic [BLK_W-1:0] dout,
  input logic             accept,
  input logic             busy,
  input logic [3*BLK_W-1:0] keys_q
);
  localparam int CNT_W = $clog2(LATENCY + 1);
  logic [CNT_W-1:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (rst)                 lat_cnt <= '0;
    else if (accept)         lat_cnt <= CNT_W'(1);
    else if (done)           lat_cnt <= '0;
    else if (lat_cnt != '0)  lat_cnt <= lat_cnt + CNT_W'(1);
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst) done |-> lat_cnt == CNT_W'(LATENCY)); // R7
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(dout)); // R9
  AST_KEYS_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst) !accept |=> $stable(keys_q)); // R10
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst) accept |=> busy && !done); // R7
endmodule

bind tdes_engine tdes_engine_chk u_chk (
  .clk(clk), .rst(rst), .done(done), .dout(dout), .accept(acc), .busy(busy),
  .keys_q({kq_a, kq_b, kq_c})
);

// File: tb/tdes_engine_tb.sv
module tdes_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;
  localparam logic [1:0] M_EEE3 = 2'b00, M_EDE3 = 2'b01, M_EEE2 = 2'b10, M_EDE2 = 2'b11;
  localparam logic [63:0] KA  = 64'h0E329232EA6D0D73;
  localparam logic [63:0] KB  = 64'h133457799BBCDFF1;
  localparam logic [63:0] KBP = 64'h123556789ABDDEF0;
  localparam logic [63:0] KW  = 64'h0101010101010101;
  localparam logic [63:0] KN  = 64'h0123456789ABCDEF;
  localparam logic [63:0] PB  = 64'h0123456789ABCDEF;
  localparam logic [63:0] CB  = 64'h85E813540F0AB405;
  localparam logic [63:0] PN  = 64'h4E6F772069732074;
  localparam logic [63:0] CN  = 64'h3FA40E8A984D4815;
  localparam logic [63:0] PA  = 64'h8787878787878787;

  typedef struct {
    logic [63:0] exp;
    bit          chk;
    int          t0;
    string       tag;
  } item_t;

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0, decrypt = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [63:0] key_a = '0, key_b = '0, key_c = '0, din = '0;
  logic [63:0] dout;
  logic        done;

  item_t       sb_q[$];
  int          n_cmp = 0, n_bad = 0, n_done = 0, n_push = 0, cyc = 0;
  logic [63:0] last_res = '0;

  tdes_engine u_dut (
    .clk(clk), .rst(rst), .start(start), .decrypt(decrypt), .mode(mode),
    .key_a(key_a), .key_b(key_b), .key_c(key_c), .din(din),
    .dout(dout), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R10 unexpected done", dout, 64'h0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (it.chk) check(dout === it.exp, it.tag, dout, it.exp);
        check(cyc - it.t0 == 49, "R7 latency", 64'(cyc - it.t0), 64'd49);
      end
      last_res = dout;
      n_done++;
    end
  end

  task automatic set_ops(input bit dec, input logic [1:0] md, input logic [63:0] a, b, c, d);
    decrypt = dec; mode = md; key_a = a; key_b = b; key_c = c; din = d;
  endtask

  task automatic push(input logic [63:0] exp, input bit chk, input string tag);
    item_t it;
    it.exp = exp; it.chk = chk; it.t0 = cyc + 1; it.tag = tag;
    sb_q.push_back(it);
    n_push++;
  endtask

  // driver: one block, waits for its result
  task automatic run_op(input bit dec, input logic [1:0] md, input logic [63:0] a, b, c, d,
                        input logic [63:0] exp, input bit chk, input string tag);
    int n0;
    @(negedge clk);
    n0 = n_done;
    push(exp, chk, tag);
    set_ops(dec, md, a, b, c, d);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (n_done == n0) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(1'b0, "watchdog", 64'(cyc), 64'(WATCHDOG));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] ct, r_eee, r_ede;
    int t1, n0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done === 1'b0, "R11 done after reset", 64'(done), 64'h0);
    check(dout === 64'h0, "R11 dout after reset", dout, 64'h0);

    // R1 single-DES answers through E-D-E with one key
    run_op(0, M_EDE3, KB, KB, KB, PB, CB, 1, "R1 kat B");
    run_op(0, M_EDE3, KN, KN, KN, PN, CN, 1, "R1 kat N");
    run_op(0, M_EDE3, KW, KW, KW, 64'h8000000000000000, 64'h95F8A5E5DD31D900, 1, "R1 kat W8");
    run_op(0, M_EDE3, KW, KW, KW, 64'h4000000000000000, 64'hDD7F121CA5015619, 1, "R1 kat W4");
    run_op(0, M_EDE3, KA, KA, KA, PA, 64'h0, 1, "R1 kat A");
    // R2 parity bits dropped
    run_op(0, M_EDE3, KBP, KBP, KBP, PB, CB, 1, "R2 parity flip");
    // R3 E-D-E encrypt: repeated keys cancel the middle pair
    run_op(0, M_EDE3, KA, KA, KB, PB, CB, 1, "R3 ede keys AAB");
    run_op(0, M_EDE3, KB, KA, KA, PB, CB, 1, "R3 ede keys BAA");
    // R4 E-D-E decrypt
    run_op(1, M_EDE3, KN, KN, KN, CN, PN, 1, "R4 dec kat N");
    run_op(1, M_EDE3, KA, KA, KB, CB, PB, 1, "R4 dec keys AAB");
    run_op(0, M_EDE3, KA, KB, KN, PN, 64'h0, 0, "R3 capture");
    ct = last_res;
    run_op(1, M_EDE3, KA, KB, KN, ct, PN, 1, "R4 round trip");
    r_ede = ct;
    // R5 three encryptions
    run_op(0, M_EEE3, KW, KW, KW, 64'h8000000000000000, 64'h95F8A5E5DD31D900, 1, "R5 eee weak");
    run_op(1, M_EEE3, KW, KW, KW, 64'h95F8A5E5DD31D900, 64'h8000000000000000, 1, "R5 ddd weak");
    run_op(0, M_EEE3, KW, KW, KA, PA, 64'h0, 1, "R5 eee keys WWA");
    run_op(0, M_EEE3, KA, KB, KN, PN, 64'h0, 0, "R5 capture");
    r_eee = last_res;
    run_op(1, M_EEE3, KA, KB, KN, r_eee, PN, 1, "R5 round trip");
    check(r_eee !== r_ede, "R5 eee differs from ede", r_eee, r_ede);
    // R6 two-key modes ignore key_c
    run_op(0, M_EEE2, KW, KW, KB, 64'h8000000000000000, 64'h95F8A5E5DD31D900, 1, "R6 eee2 kc ignored");
    run_op(0, M_EDE2, KA, KA, KB, PA, 64'h0, 1, "R6 ede2 kc ignored");
    run_op(0, M_EDE2, KA, KB, KN, PB, 64'h0, 0, "R6 capture");
    ct = last_res;
    run_op(1, M_EDE2, KA, KB, 64'hFEDCBA9876543210, ct, PB, 1, "R6 ede2 round trip");
    run_op(0, M_EEE2, KB, KN, KA, PN, 64'h0, 0, "R6 capture2");
    ct = last_res;
    run_op(1, M_EEE2, KB, KN, KW, ct, PN, 1, "R6 eee2 round trip");

    // R10 starts while busy, operand changes after acceptance, R7 back-to-back
    @(negedge clk);
    n0 = n_done;
    push(CB, 1, "R10 busy start ignored");
    set_ops(0, M_EDE3, KB, KB, KB, PB);
    start = 1'b1;
    t1 = cyc + 1;
    @(negedge clk);
    start = 1'b0;
    set_ops(1, M_EEE3, KA, KN, KW, PA);
    repeat (8) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (cyc != t1 + 48) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    push(CN, 1, "R7 back-to-back");
    set_ops(0, M_EDE3, KN, KN, KN, PN);
    @(negedge clk);
    start = 1'b0;
    set_ops(1, M_EEE2, KW, KW, KW, PB);
    while (n_done < n0 + 2) @(posedge clk);
    repeat (60) @(negedge clk);
    check(n_done == n0 + 2, "R10 one done per accepted start", 64'(n_done - n0), 64'd2);
    check(dout === CN, "R9 dout held", dout, CN);
    check(done === 1'b0, "R8 done low when idle", 64'(done), 64'h0);
    check(sb_q.size() == 0, "R10 scoreboard drained", 64'(sb_q.size()), 64'h0);
    check(n_done == n_push, "R10 done count", 64'(n_done), 64'(n_push));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule